// File: doc/BRIEF.md
# GPIO Port with Serial Peripheral Pin Sharing

This block is an 8-bit general-purpose I/O port. Software sets each pin's direction, output level and pull-up through a small register bus and reads the pin levels back. Pad levels pass through a two-flop synchronizer before they reach the readable input register or any peripheral.

Five of the pins are shared with two serial peripherals. Each peripheral supplies mode flags that take over individual pins. A clocked serial interface uses bit 0 for receive data, bit 1 for transmit data and bit 2 for its clock, which it can drive or receive. An I2C-capable interface uses bits 3 and 4 as open-drain data and clock lines when its select flag is set. Whenever a flag is clear, the pin it governs is controlled by the port registers again.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, the direction, output and pull-up registers all read 0. With all mode flags low, `pad_oe`, `pad_out` and `pad_pu` are all 0.
- R2: For any pin that no mode flag takes over, `pad_oe[i]` equals direction bit i (1 means output) and `pad_out[i]` equals output-data bit i.
- R3: `pad_pu` always equals the pull-up register, including on pins that a peripheral has taken over.
- R4: The bus address decode is 0 for direction, 1 for output data, 2 for input and 3 for pull-up. A read of address 0, 1 or 3 returns the stored register. A write to address 2 changes no register.
- R5: A read of address 2 returns `pad_in` as sampled two rising clock edges earlier, for every pin, including pins under peripheral control.
- R6: While `csi_txd_en` is 1, bit 1 is an output (`pad_oe[1]`=1) and `pad_out[1]` follows `csi_txd`, whatever the port registers hold.
- R7: While `csi_sck_drive` is 1, bit 2 is an output and `pad_out[2]` follows `csi_sck_out`. `csi_sck_in` always carries the synchronized level of bit 2.
- R8: `csi_rxd` carries the synchronized level of bit 0, two clock edges after `pad_in[0]` changes.
- R9: While `i2c_sel` is 1, bits 3 and 4 are open drain. `pad_out` is 0 on both bits. `pad_oe[3]` equals `i2c_sda_low` and `pad_oe[4]` equals `i2c_scl_low`. `i2c_sda_in` and `i2c_scl_in` carry the synchronized levels of bits 3 and 4.
- R10: When a mode flag returns to 0, the pins it governs follow the direction and output registers again in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |
| csi_txd_en | input | 1 | Clocked serial: transmit pin takeover flag |
| csi_txd | input | 1 | Clocked serial: transmit data |
| csi_sck_drive | input | 1 | Clocked serial: clock output mode flag |
| csi_sck_out | input | 1 | Clocked serial: clock to drive |
| csi_rxd | output | 1 | Clocked serial: synchronized receive data |
| csi_sck_in | output | 1 | Clocked serial: synchronized clock pin level |
| i2c_sel | input | 1 | Two-wire serial: pin takeover flag |
| i2c_sda_low | input | 1 | Two-wire serial: pull data line low |
| i2c_scl_low | input | 1 | Two-wire serial: pull clock line low |
| i2c_sda_in | output | 1 | Two-wire serial: synchronized data level |
| i2c_scl_in | output | 1 | Two-wire serial: synchronized clock level |

## Verification
The hardest case to reach is several takeovers at once, layered over register values that would push a pin the other way. An example is the transmit pin forced high while its direction bit is 0, and the I2C lines with output data bits set to 1. The vector table first writes conflicting direction and output bytes and then raises combinations of mode flags, including every flag together. Then it lowers the flags to show the registers take control back. The two-edge synchronizer delay is checked on the cycle between the edges, so an off-by-one latency shows up.

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int W       = 8,
  parameter int RX_BIT  = 0,
  parameter int TX_BIT  = 1,
  parameter int SCK_BIT = 2,
  parameter int SDA_BIT = 3,
  parameter int SCL_BIT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  input  logic         csi_txd_en,
  input  logic         csi_txd,
  input  logic         csi_sck_drive,
  input  logic         csi_sck_out,
  output logic         csi_rxd,
  output logic         csi_sck_in,
  input  logic         i2c_sel,
  input  logic         i2c_sda_low,
  input  logic         i2c_scl_low,
  output logic         i2c_sda_in,
  output logic         i2c_scl_in
);

  localparam logic [1:0] A_DIR = 2'd0;
  localparam logic [1:0] A_OUT = 2'd1;
  localparam logic [1:0] A_IN  = 2'd2;
  localparam logic [1:0] A_PU  = 2'd3;
  localparam int HI_LSB = SCL_BIT + 1;

  logic [W-1:0] dir_q, out_q, pu_q, meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      pu_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_DIR:   dir_q <= reg_wdata;
        A_OUT:   out_q <= reg_wdata;
        A_PU:    pu_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    case (reg_addr)
      A_DIR:   reg_rdata = dir_q;
      A_OUT:   reg_rdata = out_q;
      A_IN:    reg_rdata = sync_q;
      default: reg_rdata = pu_q;
    endcase
  end

  always_comb begin
    pad_oe  = dir_q;
    pad_out = out_q;
    if (csi_txd_en) begin
      pad_oe[TX_BIT]  = 1'b1;
      pad_out[TX_BIT] = csi_txd;
    end
    if (csi_sck_drive) begin
      pad_oe[SCK_BIT]  = 1'b1;
      pad_out[SCK_BIT] = csi_sck_out;
    end
    if (i2c_sel) begin
      pad_oe[SDA_BIT]  = i2c_sda_low;
      pad_oe[SCL_BIT]  = i2c_scl_low;
      pad_out[SDA_BIT] = 1'b0;
      pad_out[SCL_BIT] = 1'b0;
    end
  end

  assign pad_pu     = pu_q;
  assign csi_rxd    = sync_q[RX_BIT];
  assign csi_sck_in = sync_q[SCK_BIT];
  assign i2c_sda_in = sync_q[SDA_BIT];
  assign i2c_scl_in = sync_q[SCL_BIT];

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  p_dir_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DIR) |=> pad_oe[W-1:HI_LSB] == $past(reg_wdata[W-1:HI_LSB]));

  p_pullup_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_PU) |=> pad_pu == $past(reg_wdata));

  p_in_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_IN) |=> ($stable(dir_q) && $stable(out_q) && $stable(pu_q)));

  p_in_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2 && reg_addr == A_IN) |-> reg_rdata == $past(pad_in, 2));

  p_tx_takeover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    csi_txd_en |-> (pad_oe[TX_BIT] && pad_out[TX_BIT] == csi_txd));

  p_sck_takeover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    csi_sck_drive |-> (pad_oe[SCK_BIT] && pad_out[SCK_BIT] == csi_sck_out));

  p_rx_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> csi_rxd == $past(pad_in[RX_BIT], 2));

  p_open_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_sel |-> !((pad_oe[SDA_BIT] && pad_out[SDA_BIT]) || (pad_oe[SCL_BIT] && pad_out[SCL_BIT])));

endmodule

// File: tb/gpio_mux_port_tb.sv
module gpio_mux_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata, pad_out, pad_oe, pad_pu;
  logic [7:0] pad_in = 8'h00;
  logic csi_txd_en = 0, csi_txd = 0, csi_sck_drive = 0, csi_sck_out = 0;
  logic i2c_sel = 0, i2c_sda_low = 0, i2c_scl_low = 0;
  logic csi_rxd, csi_sck_in, i2c_sda_in, i2c_scl_in;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  gpio_mux_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .csi_txd_en(csi_txd_en), .csi_txd(csi_txd), .csi_sck_drive(csi_sck_drive),
    .csi_sck_out(csi_sck_out), .csi_rxd(csi_rxd), .csi_sck_in(csi_sck_in),
    .i2c_sel(i2c_sel), .i2c_sda_low(i2c_sda_low), .i2c_scl_low(i2c_scl_low),
    .i2c_sda_in(i2c_sda_in), .i2c_scl_in(i2c_scl_in)
  );

  // {dir, out, flags{txen,txd,sckdrv,scko,i2c,sdal,scll}, exp_oe, exp_out}
  localparam int NV = 10;
  localparam logic [38:0] VEC [NV] = '{
    {8'hF0, 8'hA5, 7'b000_0000, 8'hF0, 8'hA5},
    {8'h00, 8'hFF, 7'b100_0000, 8'h02, 8'hFD},
    {8'h00, 8'h00, 7'b110_0000, 8'h02, 8'h02},
    {8'h00, 8'h00, 7'b001_1000, 8'h04, 8'h04},
    {8'hFF, 8'hFF, 7'b001_0000, 8'hFF, 8'hFB},
    {8'hFF, 8'hFF, 7'b000_0100, 8'hE7, 8'hE7},
    {8'h00, 8'hFF, 7'b000_0110, 8'h08, 8'hE7},
    {8'h00, 8'h00, 7'b000_0101, 8'h10, 8'h00},
    {8'h00, 8'h00, 7'b111_0111, 8'h1E, 8'h02},
    {8'h1E, 8'h1E, 7'b000_0000, 8'h1E, 8'h1E}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_flags(input logic [6:0] f);
    {csi_txd_en, csi_txd, csi_sck_drive, csi_sck_out, i2c_sel, i2c_sda_low, i2c_scl_low} = f;
  endtask

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 pad_pu", pad_pu, 8'h00);
    rd(2'd0, v); check("R1 dir", v, 8'h00);
    rd(2'd1, v); check("R1 out", v, 8'h00);
    rd(2'd3, v); check("R1 pu", v, 8'h00);

    // R4 readback and ignored write to input register
    wr(2'd0, 8'h3C); wr(2'd1, 8'hC3); wr(2'd3, 8'h5A);
    rd(2'd0, v); check("R4 dir readback", v, 8'h3C);
    rd(2'd1, v); check("R4 out readback", v, 8'hC3);
    rd(2'd3, v); check("R4 pu readback", v, 8'h5A);
    wr(2'd2, 8'hFF);
    rd(2'd0, v); check("R4 dir after in-write", v, 8'h3C);
    rd(2'd1, v); check("R4 out after in-write", v, 8'hC3);
    rd(2'd3, v); check("R4 pu after in-write", v, 8'h5A);
    rd(2'd2, v); check("R4 in after in-write", v, 8'h00);
    check("R2 oe follows dir", pad_oe, 8'h3C);
    check("R2 out follows reg", pad_out, 8'hC3);

    // Table: R2 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) begin
      set_flags(7'd0);
      wr(2'd0, VEC[i][38:31]);
      wr(2'd1, VEC[i][30:23]);
      set_flags(VEC[i][22:16]);
      #1;
      check($sformatf("R2/R6/R7/R9 vec%0d oe", i), pad_oe, VEC[i][15:8]);
      check($sformatf("R2/R6/R7/R9 vec%0d out", i), pad_out, VEC[i][7:0]);
    end

    // R10 flags dropped restore registers in the same cycle
    set_flags(7'b111_0111);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    #1 check("R6 tx high dir0", pad_oe & 8'h02, 8'h02);
    set_flags(7'd0);
    #1;
    check("R10 oe after drop", pad_oe, 8'h00);
    check("R10 out after drop", pad_out, 8'h00);

    // R3 pull-up kept under peripheral control
    set_flags(7'b111_0111);
    wr(2'd3, 8'h1F);
    check("R3 pad_pu under takeover", pad_pu, 8'h1F);
    set_flags(7'd0);

    // R5 R8 R7 R9 synchronizer latency
    @(negedge clk);
    pad_in = 8'h9D;
    reg_addr = 2'd2;
    @(negedge clk);
    check("R5 not yet after one edge", reg_rdata, 8'h00);
    check("R8 rxd not yet", {7'd0, csi_rxd}, 8'h00);
    @(negedge clk);
    check("R5 input after two edges", reg_rdata, 8'h9D);
    check("R8 rxd", {7'd0, csi_rxd}, 8'h01);
    check("R7 sck_in", {7'd0, csi_sck_in}, 8'h01);
    check("R9 sda_in", {7'd0, i2c_sda_in}, 8'h01);
    check("R9 scl_in", {7'd0, i2c_scl_in}, 8'h01);

    set_flags(7'b111_1111);
    pad_in = 8'h62;
    @(negedge clk); @(negedge clk);
    reg_addr = 2'd2;
    #1;
    check("R5 input under takeover", reg_rdata, 8'h62);
    check("R8 rxd low", {7'd0, csi_rxd}, 8'h00);
    check("R7 sck_in low", {7'd0, csi_sck_in}, 8'h00);
    check("R9 sda/scl low", {6'd0, i2c_scl_in, i2c_sda_in}, 8'h00);

    // R1 reset again clears registers
    rst_n = 1'b0;
    set_flags(7'd0);
    #1;
    check("R1 oe in reset", pad_oe, 8'h00);
    check("R1 pu in reset", pad_pu, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    rd(2'd2, v); check("R1 input cleared", v, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule